// File: doc/BRIEF.md
# Branch Condition and Exit Resolver

This block keeps the control-flow state for an instruction stream where the branch decision and the control transfer are separate instructions. A branch instruction only evaluates a condition. When the condition holds, it supplies a target address. A later exit instruction makes the actual transfer. The block holds a single target register with a valid flag and a three-valued branch state. From these it answers every exit with one of three results: transfer to the held target, continue sequentially, or wait.

The issue stage signals each branch when it is issued, before its outcome is known. The resolving stage returns outcomes later, strictly in issue order and at most one per cycle. Outstanding branches keep the state unresolved. The first taken outcome captures the target, and the block then ignores further outcomes until an exit consumes that target. Outcomes that belong to branches issued before a transferring exit can still be in flight when the exit completes. These stale outcomes are counted and discarded, so they never leak into the next group. Instruction decode, condition evaluation and fetch redirection stay with the surrounding pipeline.

Top module: `branch_exit_resolver`

## Requirements
- R1: After reset, `br_state_o` reads 0 (unsuccessful), and `exit_stall_o` and `exit_done_o` are low.
- R2: A branch issue (`br_issue_i`) while the state is 0 (unsuccessful) makes the state 1 (unresolved) in the next cycle.
- R3: When the last outstanding branch of the current group resolves not taken, the state returns to 0 in the next cycle. With no issue, state 0 persists.
- R4: The first taken outcome of a group captures `br_res_target_i` and sets the state to 2 (successful) in the next cycle. From then on, `exit_target_o` shows the captured address.
- R5: While the state is 2 and no exit arrives, further outcomes, taken or not, change neither the state nor `exit_target_o`.
- R6: An exit (`exit_valid_i`) in state 2 raises `exit_done_o` and `exit_take_o` in the same cycle, with `exit_target_o` giving the target. The valid flag is consumed, and the state is not 2 in the next cycle.
- R7: An exit in state 0 raises `exit_done_o` with `exit_take_o` low in the same cycle and leaves the state unchanged. `exit_done_o` is never high without `exit_valid_i`.
- R8: An exit in state 1 raises `exit_stall_o` with `exit_done_o` low. Once the state settles, the same exit completes.
- R9: Outcomes are consumed in issue order. The state stays 1 while any branch of the group is outstanding. A taken outcome that follows not-taken outcomes still captures its target.
- R10: Outcomes of branches issued before a transferring exit are discarded when they arrive after the exit. They neither resolve nor capture for the new group.
- R11: A branch issued in the same cycle as a transferring exit belongs to the new group, so the state is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_issue_i | input | 1 | A branch with unknown outcome was issued |
| br_res_valid_i | input | 1 | Outcome of the oldest outstanding branch is present |
| br_res_taken_i | input | 1 | That outcome is taken |
| br_res_target_i | input | AW | Target address carried by a taken outcome |
| exit_valid_i | input | 1 | An exit instruction requests a decision |
| br_state_o | output | 2 | 0 unsuccessful, 1 unresolved, 2 successful |
| exit_stall_o | output | 1 | Exit must be held this cycle |
| exit_done_o | output | 1 | Exit decided this cycle |
| exit_take_o | output | 1 | Decided exit transfers control |
| exit_target_o | output | AW | Held target address |

## Verification
The bench builds the block with AW = 16 and MAX_PEND = 3. Three outstanding branches then fill the tracking counters completely, and the sequence of not-taken outcomes followed by a taken one (R9) runs at that limit. It also overlaps a transferring exit with a new issue and a still-pending old branch. This drives the stale-drop path (R10, R11) with both counters non-zero at once. A scoreboard queue holds the predicted decision for every exit. Stalled exits are held on the input across the cycles in which the state settles.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [1:0] {
    BR_UNSUCC = 2'd0,
    BR_UNRES  = 2'd1,
    BR_SUCC   = 2'd2
  } br_state_e;
endpackage

// File: rtl/bxr_track.sv
// Outstanding-branch tracking: live group and stale (pre-exit) outcomes.
module bxr_track #(
  parameter int MAX_PEND = 8,
  localparam int CW = $clog2(MAX_PEND + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic res_valid_i,
  input  logic xfer_i,
  output logic res_live_o,
  output logic live_any_o
);
  logic [CW-1:0] live_q, drop_q, live_after, drop_after;
  logic          drop_hit;

  assign drop_hit   = res_valid_i && (drop_q != '0);
  assign res_live_o = res_valid_i && (drop_q == '0);
  assign live_after = live_q - CW'(res_live_o);
  assign drop_after = drop_q - CW'(drop_hit);
  assign live_any_o = (live_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      drop_q <= '0;
    end else if (xfer_i) begin
      drop_q <= drop_after + live_after;
      live_q <= CW'(issue_i);
    end else begin
      drop_q <= drop_after;
      live_q <= live_after + CW'(issue_i);
    end
  end
endmodule

// File: rtl/bxr_eba.sv
// Effective target register with valid flag; clear wins over load.
module bxr_eba #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clear_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end else if (load_i && !valid_o) begin
      addr_o  <= addr_i;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/bxr_exit.sv
module bxr_exit
  import bxr_pkg::*;
(
  input  br_state_e state_i,
  input  logic      exit_valid_i,
  output logic      stall_o,
  output logic      done_o,
  output logic      take_o
);
  always_comb begin
    stall_o = 1'b0;
    done_o  = 1'b0;
    take_o  = 1'b0;
    if (exit_valid_i) begin
      unique case (state_i)
        BR_UNRES: stall_o = 1'b1;
        BR_SUCC: begin
          done_o = 1'b1;
          take_o = 1'b1;
        end
        default: done_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/branch_exit_resolver.sv
module branch_exit_resolver
  import bxr_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MAX_PEND = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          br_issue_i,
  input  logic          br_res_valid_i,
  input  logic          br_res_taken_i,
  input  logic [AW-1:0] br_res_target_i,
  input  logic          exit_valid_i,
  output logic [1:0]    br_state_o,
  output logic          exit_stall_o,
  output logic          exit_done_o,
  output logic          exit_take_o,
  output logic [AW-1:0] exit_target_o
);
  br_state_e state;
  logic      res_live, live_any, eba_vld, xfer, load;

  bxr_track #(.MAX_PEND(MAX_PEND)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (br_issue_i),
    .res_valid_i(br_res_valid_i),
    .xfer_i     (xfer),
    .res_live_o (res_live),
    .live_any_o (live_any)
  );

  assign load = res_live && br_res_taken_i;

  bxr_eba #(.AW(AW)) u_eba (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .clear_i(xfer),
    .addr_i (br_res_target_i),
    .addr_o (exit_target_o),
    .valid_o(eba_vld)
  );

  always_comb begin
    if (eba_vld)       state = BR_SUCC;
    else if (live_any) state = BR_UNRES;
    else               state = BR_UNSUCC;
  end

  bxr_exit u_exit (
    .state_i     (state),
    .exit_valid_i(exit_valid_i),
    .stall_o     (exit_stall_o),
    .done_o      (exit_done_o),
    .take_o      (exit_take_o)
  );

  assign xfer       = exit_take_o;
  assign br_state_o = state;
endmodule

// File: rtl/bxr_checker.sv
module bxr_checker
  import bxr_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          br_issue_i,
  input logic          exit_valid_i,
  input logic [1:0]    br_state_o,
  input logic          exit_stall_o,
  input logic          exit_done_o,
  input logic          exit_take_o,
  input logic [AW-1:0] exit_target_o
);
  a_r2_issue_unresolves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_state_o == BR_UNSUCC && br_issue_i) |=> br_state_o == BR_UNRES);

  a_r3_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_state_o == BR_UNSUCC && !br_issue_i) |=> br_state_o == BR_UNSUCC);

  a_r5_succ_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_state_o == BR_SUCC && !exit_valid_i) |=>
      (br_state_o == BR_SUCC && $stable(exit_target_o)));

  a_r6_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_done_o && exit_take_o) |=> br_state_o != BR_SUCC);

  a_r7_done_needs_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_done_o |-> exit_valid_i);

  a_r8_stall_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_stall_o |-> (!exit_done_o && !exit_take_o));
endmodule

bind branch_exit_resolver bxr_checker #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .br_issue_i   (br_issue_i),
  .exit_valid_i (exit_valid_i),
  .br_state_o   (br_state_o),
  .exit_stall_o (exit_stall_o),
  .exit_done_o  (exit_done_o),
  .exit_take_o  (exit_take_o),
  .exit_target_o(exit_target_o)
);

// File: tb/branch_exit_resolver_tb.sv
module branch_exit_resolver_tb;
  localparam int AW = 16;
  localparam int MP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss = 1'b0, rv = 1'b0, rt = 1'b0, ev = 1'b0;
  logic [AW-1:0] tg = '0;
  logic [1:0]    st;
  logic          stall, done, take;
  logic [AW-1:0] tgt;

  int n_cmp = 0, n_bad = 0;
  logic [AW:0] exp_q[$];

  always #2.5 clk = ~clk;

  branch_exit_resolver #(.AW(AW), .MAX_PEND(MP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .br_issue_i(iss), .br_res_valid_i(rv),
    .br_res_taken_i(rt), .br_res_target_i(tg), .exit_valid_i(ev),
    .br_state_o(st), .exit_stall_o(stall), .exit_done_o(done),
    .exit_take_o(take), .exit_target_o(tgt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_st(input int exp, input string tag);
    chk(int'(st) == exp, tag, int'(st), exp);
  endtask

  // drive one cycle at the falling edge, return just before the next rising edge
  task automatic step(input logic i, input logic v, input logic t,
                      input logic [AW-1:0] a, input logic e);
    @(negedge clk);
    iss = i; rv = v; rt = t; tg = a; ev = e;
    #2;
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0);
  endtask

  task automatic push_exp(input logic t, input logic [AW-1:0] a);
    exp_q.push_back({t, a});
  endtask

  // monitor: compare every decided exit against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected exit decision", 1, 0);
      end else begin
        logic [AW:0] e;
        e = exp_q.pop_front();
        chk(take == e[AW], "R6/R7 exit take", int'(take), int'(e[AW]));
        if (e[AW]) chk(tgt == e[AW-1:0], "R6 exit target", int'(tgt), int'(e[AW-1:0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1
    chk_st(0, "R1 reset state");
    chk(!stall && !done, "R1 exit outputs idle", int'(stall) + int'(done), 0);

    // R7: exit with nothing pending continues sequentially
    push_exp(0, '0);
    step(0, 0, 0, '0, 1);
    idle();
    chk_st(0, "R7 state unchanged");

    // R2
    step(1, 0, 0, '0, 0);
    idle();
    chk_st(1, "R2 unresolved after issue");

    // R8: exit stalls while unresolved, completes once resolved
    step(0, 0, 0, '0, 1);
    chk(stall == 1'b1, "R8 stall", int'(stall), 1);
    step(0, 1, 0, '0, 1);
    chk(stall == 1'b1, "R8 stall held", int'(stall), 1);
    push_exp(0, '0);
    step(0, 0, 0, '0, 1);
    chk(stall == 1'b0, "R8 stall released", int'(stall), 0);
    chk_st(0, "R3 back to unsuccessful");
    idle();

    // R9: three outstanding (MAX_PEND), in-order resolution
    step(1, 0, 0, '0, 0);
    step(1, 0, 0, '0, 0);
    step(1, 0, 0, '0, 0);
    idle();
    chk_st(1, "R9 full pending unresolved");
    step(0, 1, 0, 16'h1111, 0);
    idle();
    chk_st(1, "R9 still unresolved");
    step(0, 1, 1, 16'h2A40, 0);
    idle();
    chk_st(2, "R4 successful");
    chk(tgt == 16'h2A40, "R4 captured target", int'(tgt), 'h2A40);
    step(0, 1, 1, 16'h5555, 0);
    idle();
    chk_st(2, "R5 still successful");
    chk(tgt == 16'h2A40, "R5 later taken ignored", int'(tgt), 'h2A40);
    push_exp(1, 16'h2A40);
    step(0, 0, 0, '0, 1);
    idle();
    chk_st(0, "R6 consumed");

    // R10/R11: stale outcome after a transferring exit
    step(1, 0, 0, '0, 0);
    step(1, 0, 0, '0, 0);
    step(0, 1, 1, 16'h0B10, 0);
    idle();
    chk_st(2, "R4 successful with one pending");
    push_exp(1, 16'h0B10);
    step(1, 0, 0, '0, 1);
    idle();
    chk_st(1, "R11 issue with exit joins new group");
    step(0, 1, 1, 16'h0C00, 0);
    idle();
    chk_st(1, "R10 stale outcome discarded");
    step(0, 1, 1, 16'h0C11, 0);
    idle();
    chk_st(2, "R10 new group captures");
    chk(tgt == 16'h0C11, "R10 new target", int'(tgt), 'h0C11);
    push_exp(1, 16'h0C11);
    step(0, 0, 0, '0, 1);
    idle();
    chk_st(0, "R6 consumed again");
    idle();
    chk(exp_q.size() == 0, "R6 all exits decided", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule